// File: doc/BRIEF.md
# Bit Butterfly Permute Unit

This is a combinational bit-permutation unit for 64-bit operands. One control word picks which power-of-two stages of a butterfly network are active. Four operations share that structure. Group swap exchanges each pair of neighbouring bit groups at every active stage. OR-fold ORs each group with its neighbour instead of replacing it. Zip interleaves the two halves of each bit group. Unzip undoes a zip that used the same control word.

A word-mode flag restricts the operation to the low 32 bits. In that mode the high input bits are ignored and the result is zero-extended. A datapath places the unit between operand read and writeback. It drives the operand, the stage mask and the operation select, and it takes the result in the same cycle.

Top module: `bperm_unit`

## Requirements
- R1: The operation select `op` is encoded as 2'b00 group swap, 2'b01 OR-fold, 2'b10 zip, 2'b11 unzip. The result `dout` depends only on the present inputs, with no clock and no state. With every input at zero, `dout` is zero.
- R2: For group swap in 64-bit mode, result bit i equals operand bit (i XOR ctrl), using all six control bits. With ctrl = 63 the result is the full bit reversal of the operand.
- R3: For OR-fold, stages are applied for k = 0 upward. At each stage k whose control bit is set, every bit i becomes itself OR bit (i XOR 2^k) of the previous stage value.
- R4: Zip applies its stages for k = 4 down to 0 in 64-bit mode. At each stage k whose control bit is set, every bit takes the value at the index with bits k and k+1 exchanged. With ctrl = 31, operand 0x00000000FFFFFFFF zips to 0x5555555555555555.
- R5: Unzip applies the same stages in the order k = 0 upward. Unzip of zip with the same control word returns the original operand, in both modes.
- R6: A control word of zero leaves the operand unchanged for every operation (zero-extended low half in word mode).
- R7: With `word_mode` = 1, only `din[31:0]` is used, and `dout[63:32]` is zero for every operation.
- R8: In word mode, group swap and OR-fold ignore ctrl bit 5. Zip and unzip ignore ctrl bits 5 and 4, and their stages run k = 3 down to 0 (zip) or 0 up to 3 (unzip).
- R9: In 64-bit mode, zip and unzip ignore ctrl bit 5.
- R10: Group swap, zip and unzip keep the number of set bits of the (masked) operand. OR-fold never clears a bit that is set in the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 64 | Operand |
| ctrl | input | 6 | Stage-enable mask, bit k enables stage of distance 2^k |
| op | input | 2 | Operation select (R1 encoding) |
| word_mode | input | 1 | 1 = operate on low 32 bits, zero-extend result |
| dout | output | 64 | Result |

## Verification
The unit holds no state, so any internal fault shows on `dout` in the same evaluation as the inputs that expose it. A wrong stage mask or stage order affects only the control words that enable that stage. For this reason the round-trip test sweeps every control value in both modes. A misplaced stage order breaks zip/unzip inversion immediately, and a word-mode leak shows as nonzero upper bits. The reference model works on bit indices (XOR and bit-pair exchange) rather than masks, so a mask typo cannot hide in a shared formula.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
   typedef enum logic [1:0] {
      OP_SWAP  = 2'b00,
      OP_FOLD  = 2'b01,
      OP_ZIP   = 2'b10,
      OP_UNZIP = 2'b11
   } bperm_op_e;
endpackage

// File: rtl/bperm_swap_stage.sv
// One butterfly level: exchanges neighbouring groups of 2^K bits,
// or ORs the exchanged value into the input when fold is set.
module bperm_swap_stage #(
   parameter int DATA_W = 64,
   parameter int K      = 0
) (
   input  logic [DATA_W-1:0] x,
   input  logic              en,
   input  logic              fold,
   output logic [DATA_W-1:0] y
);
   localparam int DIST = 1 << K;

   function automatic logic [DATA_W-1:0] low_groups();
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) m[i] = ((i >> K) & 1) == 0;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] LO = low_groups();

   logic [DATA_W-1:0] crossed;

   always_comb begin
      crossed = ((x & LO) << DIST) | ((x & ~LO) >> DIST);
      if (!en)       y = x;
      else if (fold) y = x | crossed;
      else           y = crossed;
   end

   // R10
   always_comb begin
      if (!$isunknown({x, en, fold}) && en && !fold)
         swap_popcount_chk: assert ($countones(y) == $countones(x));
   end
endmodule

// File: rtl/bperm_zip_stage.sv
// One position of the zip chain. The stage distance differs with the
// direction: zip walks from the widest level down, unzip walks up.
module bperm_zip_stage #(
   parameter int DATA_W = 64,
   parameter int K_FWD  = 0,
   parameter int K_BWD  = 0
) (
   input  logic [DATA_W-1:0] x,
   input  logic              en_fwd,
   input  logic              en_bwd,
   input  logic              backward,
   output logic [DATA_W-1:0] y
);
   function automatic logic [DATA_W-1:0] quarter_mask(int k, int code);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) m[i] = ((i >> k) & 3) == code;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] FL = quarter_mask(K_FWD, 2);
   localparam logic [DATA_W-1:0] FR = quarter_mask(K_FWD, 1);
   localparam logic [DATA_W-1:0] BL = quarter_mask(K_BWD, 2);
   localparam logic [DATA_W-1:0] BR = quarter_mask(K_BWD, 1);

   logic [DATA_W-1:0] zf, zb;

   always_comb begin
      zf = (x & ~(FL | FR)) | ((x << (1 << K_FWD)) & FL) | ((x >> (1 << K_FWD)) & FR);
      zb = (x & ~(BL | BR)) | ((x << (1 << K_BWD)) & BL) | ((x >> (1 << K_BWD)) & BR);
      if (backward) y = en_bwd ? zb : x;
      else          y = en_fwd ? zf : x;
   end

   // R10
   always_comb begin
      if (!$isunknown({x, en_fwd, en_bwd, backward}))
         zip_popcount_chk: assert ($countones(y) == $countones(x));
   end
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
   import bperm_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LVL    = $clog2(DATA_W),
   localparam int ZLVL   = LVL - 1,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LVL-1:0]    ctrl,
   input  logic [1:0]        op,
   input  logic              word_mode,
   output logic [DATA_W-1:0] dout
);
   if (DATA_W < 8 || (1 << LVL) != DATA_W) begin : g_bad_width
      $error("bperm_unit: DATA_W must be a power of two of at least 8");
   end

   logic [DATA_W-1:0] x0;
   logic [LVL-1:0]    en_swap;
   logic [ZLVL-1:0]   en_zip;
   logic [DATA_W-1:0] sw [LVL+1];
   logic [DATA_W-1:0] zp [ZLVL+1];
   logic              is_fold, is_unzip;

   assign x0       = word_mode ? {{HALF_W{1'b0}}, din[HALF_W-1:0]} : din;
   assign is_fold  = (op == OP_FOLD);
   assign is_unzip = (op == OP_UNZIP);

   // Word mode drops the widest level of each chain.
   for (genvar k = 0; k < LVL; k++) begin : g_swap_en
      if (k == LVL - 1) begin : g_top
         assign en_swap[k] = ctrl[k] & ~word_mode;
      end else begin : g_rest
         assign en_swap[k] = ctrl[k];
      end
   end

   for (genvar k = 0; k < ZLVL; k++) begin : g_zip_en
      if (k == ZLVL - 1) begin : g_top
         assign en_zip[k] = ctrl[k] & ~word_mode;
      end else begin : g_rest
         assign en_zip[k] = ctrl[k];
      end
   end

   assign sw[0] = x0;
   for (genvar k = 0; k < LVL; k++) begin : g_swap
      bperm_swap_stage #(.DATA_W(DATA_W), .K(k)) u_stage (
         .x    (sw[k]),
         .en   (en_swap[k]),
         .fold (is_fold),
         .y    (sw[k+1])
      );
   end

   assign zp[0] = x0;
   for (genvar p = 0; p < ZLVL; p++) begin : g_zip
      bperm_zip_stage #(.DATA_W(DATA_W), .K_FWD(ZLVL-1-p), .K_BWD(p)) u_stage (
         .x        (zp[p]),
         .en_fwd   (en_zip[ZLVL-1-p]),
         .en_bwd   (en_zip[p]),
         .backward (is_unzip),
         .y        (zp[p+1])
      );
   end

   assign dout = op[1] ? zp[ZLVL] : sw[LVL];

   always_comb begin
      if (!$isunknown({din, ctrl, op, word_mode})) begin
         // R7
         word_hi_zero_chk: assert (!word_mode || dout[DATA_W-1:HALF_W] == '0);
         // R6
         idle_ctrl_chk: assert (ctrl != '0 ||
            dout == (word_mode ? {{HALF_W{1'b0}}, din[HALF_W-1:0]} : din));
         // R10
         fold_keep_chk: assert (op != OP_FOLD || (dout & x0) == x0);
      end
   end
endmodule

// File: tb/bperm_unit_bench.sv
module bperm_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] din;
   logic [5:0]  ctrl;
   logic [1:0]  op;
   logic        word_mode;
   logic [63:0] dout;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;
   logic [63:0] seed = 64'h9E3779B97F4A7C15;

   always #(CLK_PERIOD/2) clk = ~clk;

   bperm_unit u_bperm_unit (
      .din(din), .ctrl(ctrl), .op(op), .word_mode(word_mode), .dout(dout)
   );

   function automatic logic [63:0] next_rand(logic [63:0] s);
      logic [63:0] t = s;
      t ^= t << 13; t ^= t >> 7; t ^= t << 17;
      return t;
   endfunction

   // Index-based reference model.
   function automatic logic [63:0] model(logic [1:0] o, logic [63:0] x,
                                         logic [5:0] c, logic w);
      int n = w ? 32 : 64;
      int sl = w ? 5 : 6;
      int zl = w ? 4 : 5;
      logic [63:0] y = w ? {32'h0, x[31:0]} : x;
      logic [63:0] t;
      int cm = w ? (c & 31) : c;
      if (o == 2'b00) begin
         t = '0;
         for (int i = 0; i < n; i++) t[i] = y[i ^ cm];
         return t;
      end
      if (o == 2'b01) begin
         for (int k = 0; k < sl; k++) if (c[k]) begin
            t = y;
            for (int i = 0; i < n; i++) t[i] = y[i] | y[i ^ (1 << k)];
            y = t;
         end
         return y;
      end
      for (int s = 0; s < zl; s++) begin
         int k = (o == 2'b10) ? (zl - 1 - s) : s;
         if (c[k]) begin
            t = '0;
            for (int i = 0; i < n; i++) begin
               int b0 = (i >> k) & 1;
               int b1 = (i >> (k + 1)) & 1;
               int j = (i & ~(3 << k)) | (b0 << (k + 1)) | (b1 << k);
               t[i] = y[j];
            end
            y = t;
         end
      end
      return y;
   endfunction

   task automatic apply(input logic [1:0] o, input logic [63:0] x,
                        input logic [5:0] c, input logic w, output logic [63:0] r);
      @(negedge clk);
      op = o; din = x; ctrl = c; word_mode = w;
      #(CLK_PERIOD/4);
      r = dout;
   endtask

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic t_idle();
      logic [63:0] r;
      apply(2'b00, 64'h0, 6'h0, 1'b0, r);
      check("R1 zero inputs", r, 64'h0);
   endtask

   task automatic t_swap();
      logic [63:0] r, exp;
      apply(2'b00, 64'h0123456789ABCDEF, 6'd63, 1'b0, r);
      for (int i = 0; i < 64; i++) exp[i] = 64'h0123456789ABCDEF >> (63 - i);
      check("R2 full reversal", r, exp);
      for (int c = 1; c < 64; c += 5) begin
         seed = next_rand(seed);
         apply(2'b00, seed, 6'(c), 1'b0, r);
         check("R2 swap", r, model(2'b00, seed, 6'(c), 1'b0));
      end
   endtask

   task automatic t_fold();
      logic [63:0] r;
      apply(2'b01, 64'h0000000000000001, 6'd63, 1'b0, r);
      check("R3 fold all", r, 64'hFFFFFFFFFFFFFFFF);
      apply(2'b01, 64'h8000000000000010, 6'd7, 1'b0, r);
      check("R3 fold bytes", r, 64'hFF000000000000FF);
      for (int c = 2; c < 64; c += 7) begin
         seed = next_rand(seed) & next_rand(seed ^ 64'h5A5A);
         apply(2'b01, seed, 6'(c), 1'b0, r);
         check("R3 fold", r, model(2'b01, seed, 6'(c), 1'b0));
         check("R10 fold keeps bits", r & seed, seed);
      end
   endtask

   task automatic t_zip();
      logic [63:0] r;
      apply(2'b10, 64'h00000000FFFFFFFF, 6'd31, 1'b0, r);
      check("R4 full zip", r, 64'h5555555555555555);
      for (int c = 1; c < 32; c += 3) begin
         seed = next_rand(seed);
         apply(2'b10, seed, 6'(c), 1'b0, r);
         check("R4 zip", r, model(2'b10, seed, 6'(c), 1'b0));
         check("R10 zip popcount", 64'($countones(r)), 64'($countones(seed)));
         apply(2'b11, seed, 6'(c), 1'b0, r);
         check("R5 unzip", r, model(2'b11, seed, 6'(c), 1'b0));
      end
   endtask

   task automatic t_roundtrip();
      logic [63:0] a, b, x;
      for (int w = 0; w < 2; w++)
         for (int c = 0; c < 64; c++) begin
            seed = next_rand(seed);
            x = w ? {32'h0, seed[31:0]} : seed;
            apply(2'b10, seed, 6'(c), 1'(w), a);
            apply(2'b11, a, 6'(c), 1'(w), b);
            check("R5 round trip", b, x);
         end
   endtask

   task automatic t_identity();
      logic [63:0] r;
      for (int o = 0; o < 4; o++) begin
         apply(2'(o), 64'hDEADBEEFCAFEF00D, 6'h0, 1'b0, r);
         check("R6 identity", r, 64'hDEADBEEFCAFEF00D);
         apply(2'(o), 64'hDEADBEEFCAFEF00D, 6'h0, 1'b1, r);
         check("R6 identity word", r, 64'h00000000CAFEF00D);
      end
   endtask

   task automatic t_word();
      logic [63:0] r;
      apply(2'b00, 64'hFFFFFFFF00000001, 6'd31, 1'b1, r);
      check("R7 word reversal", r, 64'h0000000080000000);
      for (int o = 0; o < 4; o++) begin
         seed = next_rand(seed);
         apply(2'(o), seed, 6'd27, 1'b1, r);
         check("R7 word op", r, model(2'(o), seed, 6'd27, 1'b1));
      end
   endtask

   task automatic t_ignore();
      logic [63:0] a, b;
      for (int o = 0; o < 4; o++) begin
         seed = next_rand(seed);
         apply(2'(o), seed, 6'b001101, 1'b1, a);
         apply(2'(o), seed, (o >= 2) ? 6'b111101 : 6'b101101, 1'b1, b);
         check("R8 word ignores high ctrl", b, a);
      end
      seed = next_rand(seed);
      apply(2'b10, seed, 6'b010110, 1'b0, a);
      apply(2'b10, seed, 6'b110110, 1'b0, b);
      check("R9 zip ignores ctrl5", b, a);
      apply(2'b11, seed, 6'b010110, 1'b0, a);
      apply(2'b11, seed, 6'b110110, 1'b0, b);
      check("R9 unzip ignores ctrl5", b, a);
   endtask

   initial begin
      din = '0; ctrl = '0; op = '0; word_mode = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_swap();
      t_fold();
      t_zip();
      t_roundtrip();
      t_identity();
      t_word();
      t_ignore();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule